// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It does this by walking a two-level page table held in an external memory. A translation request arrives over a valid/ready handshake together with a root pointer to the first-level table. The 20-bit page number splits into two 10-bit indices. The upper index picks a first-level entry. That entry names a second-level table, and the lower index picks the entry inside it. The second-level entry supplies the frame number. The low 12 bits of the logical address pass through untouched. The two reads depend on each other, so the block runs them one after the other. It keeps a single translation in flight.

Each table entry is a 32-bit word. Bit 0 is its valid flag, and bits 31:12 hold a 4 KB-aligned base, which is either a table base or a frame base. Bits 11:1 are ignored. If either entry is marked invalid, the block reports a fault instead of an address. The external memory has one read port and a fixed read latency of one cycle. Read addresses are byte addresses.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_rd is 0.
- R2: In the cycle after a request is accepted, the block asserts mem_rd for exactly one cycle, with mem_addr = req_root + 4 × req_vaddr[31:22] (modulo 2^32).
- R3: When the first-level entry has bit 0 set, the second read is issued two cycles after the first, for one cycle, with mem_addr = {entry[31:12], 12'h000} + 4 × req_vaddr[21:12].
- R4: When both entries have bit 0 set, the response carries rsp_fault = 0 and rsp_paddr = {second_entry[31:12], req_vaddr[11:0]}. Bits 11:1 of both entries have no effect.
- R5: When the first-level entry has bit 0 clear, the block issues no second read and responds with rsp_fault = 1 and rsp_paddr = 0.
- R6: When the second-level entry has bit 0 clear, the block responds after two reads with rsp_fault = 1 and rsp_paddr = 0.
- R7: req_ready is 0 from the cycle after acceptance until the response handshake completes. This holds even while req_valid is high. req_ready returns to 1 in the cycle after the handshake.
- R8: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_paddr and rsp_fault hold their values.
- R9: rsp_valid rises on the 4th clock edge after the accepting edge for a two-read walk. For a walk that faults on the first-level entry, it rises on the 2nd edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_root | input | 32 | Byte address of the first-level table |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Walk hit an invalid entry |

## Verification
A response handshake and a new request can arrive in the same cycle. The consumer may take the response while the producer already holds req_valid high with the next address. The bench provokes this by raising req_valid with a fresh request in the same cycle that rsp_ready is high. It then requires req_ready to stay 0 in that cycle, to rise in the next cycle, and the new walk to begin only then with the new address. Some walks also hold rsp_ready low for several cycles while a request waits, and the bench checks that the response stays frozen and nothing is accepted during that time.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] req_root,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] mem_rdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_fault
);
  localparam int BASE_W = AW - OFF_W;
  localparam int PAD_W  = AW - IDX_W - 2;

  typedef enum logic [2:0] {S_IDLE, S_RD_OUT, S_WT_OUT, S_RD_IN, S_WT_IN, S_DONE} st_t;

  st_t              st;
  logic [AW-1:0]    va_q, root_q, paddr_q;
  logic [BASE_W-1:0] tbl_q;
  logic             fault_q;

  wire [IDX_W-1:0] hi_idx = va_q[AW-1 -: IDX_W];
  wire [IDX_W-1:0] lo_idx = va_q[AW-IDX_W-1 -: IDX_W];
  wire [AW-1:0] hi_off = {{PAD_W{1'b0}}, hi_idx, 2'b00};
  wire [AW-1:0] lo_off = {{PAD_W{1'b0}}, lo_idx, 2'b00};
  wire entry_ok = mem_rdata[0];
  wire unused_ok = ^mem_rdata[OFF_W-1:1];

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign mem_rd    = (st == S_RD_OUT) || (st == S_RD_IN);
  assign mem_addr  = (st == S_RD_IN) ? ({tbl_q, {OFF_W{1'b0}}} + lo_off) : (root_q + hi_off);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      tbl_q   <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          root_q  <= req_root;
          fault_q <= 1'b0;
          st      <= S_RD_OUT;
        end
        S_RD_OUT: st <= S_WT_OUT;
        S_WT_OUT: if (entry_ok) begin
          tbl_q <= mem_rdata[AW-1:OFF_W];
          st    <= S_RD_IN;
        end else begin
          fault_q <= 1'b1;
          paddr_q <= '0;
          st      <= S_DONE;
        end
        S_RD_IN: st <= S_WT_IN;
        S_WT_IN: begin
          fault_q <= !entry_ok;
          paddr_q <= entry_ok ? {mem_rdata[AW-1:OFF_W], va_q[OFF_W-1:0]} : '0;
          st      <= S_DONE;
        end
        S_DONE: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW    = 32,
  parameter int IDX_W = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_vaddr,
  input logic [AW-1:0] req_root,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_paddr,
  input logic          rsp_fault
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd && !rsp_valid);
  p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_rd &&
      mem_addr == $past(req_root) + {{(AW-IDX_W-2){1'b0}}, $past(req_vaddr[AW-1 -: IDX_W]), 2'b00});
  p_read_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> req_ready && !rsp_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));
  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_paddr == '0);
endmodule

bind pt_walker pt_walker_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_root(req_root), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault));

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 0;
  logic [31:0] req_vaddr = 0, req_root = 0;
  logic mem_rd, req_ready, rsp_valid, rsp_fault;
  logic [31:0] mem_addr, mem_rdata, rsp_paddr;
  logic [31:0] mem [0:4095];
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pt_walker u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault));

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[13:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] root, input logic [31:0] va, input int hold,
                      input bit ovl, input logic [31:0] nroot, input logic [31:0] nva);
    logic [31:0] e0, e1, a0, a1, exp_pa;
    bit exp_f;
    int nrd, n;
    logic [31:0] ra [2];
    e0 = mem[(root + {20'b0, va[31:22], 2'b00}) >> 2 & 32'hFFF];
    a0 = root + {20'b0, va[31:22], 2'b00};
    a1 = {e0[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
    e1 = mem[a1[13:2]];
    exp_f  = !e0[0] || !e1[0];
    exp_pa = exp_f ? 32'h0 : {e1[31:12], va[11:0]};
    req_valid = 1; req_root = root; req_vaddr = va; rsp_ready = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    nrd = 0; n = 1;
    while (!rsp_valid && n < 20) begin
      if (mem_rd) begin
        if (nrd < 2) ra[nrd] = mem_addr;
        if (nrd == 1) chk(n == 3, "R3 second read cycle", n, 3);
        nrd++;
      end
      @(negedge clk); n++;
    end
    chk(ra[0] == a0, "R2 first read addr", ra[0], a0);
    if (e0[0]) begin
      chk(nrd == 2, "R3 read count", nrd, 2);
      chk(ra[1] == a1, "R3 second read addr", ra[1], a1);
      chk(n == 5, "R9 latency two reads", n, 5);
      if (e1[0]) chk(rsp_paddr == exp_pa && !rsp_fault, "R4 paddr", rsp_paddr, exp_pa);
      else chk(rsp_fault && rsp_paddr == 0, "R6 inner fault", {rsp_fault, rsp_paddr[30:0]}, 32'h80000000);
    end else begin
      chk(nrd == 1, "R5 read count", nrd, 1);
      chk(n == 3, "R9 latency outer fault", n, 3);
      chk(rsp_fault && rsp_paddr == 0, "R5 outer fault", {rsp_fault, rsp_paddr[30:0]}, 32'h80000000);
    end
    for (int k = 0; k < hold; k++) begin
      req_valid = 1;
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == exp_pa && rsp_fault == exp_f, "R8 held response", rsp_paddr, exp_pa);
      chk(!req_ready && !mem_rd, "R7 busy while held", req_ready, 0);
    end
    req_valid = 0;
    if (ovl) begin
      req_valid = 1; req_root = nroot; req_vaddr = nva;
    end
    rsp_ready = 1;
    #0;
    chk(!req_ready, "R7 no accept at handshake", req_ready, 0);
    @(negedge clk);
    rsp_ready = 0;
    chk(req_ready && !rsp_valid && !mem_rd, "R7 ready after handshake", req_ready, 1);
  endtask

  initial begin
    for (int t = 0; t < 4; t++)
      for (int j = 0; j < 1024; j++)
        if (t == 0)
          mem[j] = ((((j % 3) + 1) << 12) | ((j % 4 != 3) ? 1 : 0) | ((j & 7) << 3));
        else
          mem[t*1024 + j] = (((t * 32'h100 + j * 7 + 32'h40000) << 12) |
                             ((j % 5 != 4) ? 1 : 0) | 32'h6);
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd, "R1 reset state", {req_ready, rsp_valid, mem_rd}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd, "R1 idle after reset", {req_ready, rsp_valid, mem_rd}, 3'b100);
    for (int o = 0; o < 1024; o++) begin
      logic [31:0] va, nva;
      va  = {o[9:0], 10'((o * 37) % 1024), 12'((o * 291) % 4096)};
      nva = {10'(o + 1), 10'(((o + 1) * 37) % 1024), 12'(((o + 1) * 291) % 4096)};
      walk(32'h0, va, (o % 7 == 0) ? 3 : 0, o % 2 == 1, 32'h0, nva);
    end
    for (int j = 0; j < 1024; j++)
      walk(32'h0, {10'd0, j[9:0], 12'(j * 13)}, 0, 0, 0, 0);
    for (int o = 0; o < 512; o++)
      walk(32'h800, {o[9:0], 10'((o * 5) % 1024), 12'hABC}, (o % 11 == 0) ? 2 : 0, o % 3 == 0,
           32'h800, {10'(o + 1), 10'(((o + 1) * 5) % 1024), 12'hABC});
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule